// File: doc/BRIEF.md
# Dual-Carrier Buck-Boost Gate Modulator

This block drives the eight gates of two bidirectional four-switch buck-boost power stages: one stage sits between a battery bank and a DC bus, the other between a supercapacitor module and the same bus. Each stage receives its own 16-bit duty word. The top bit of that word selects the stage's mode. In step-up mode the input-side switch pair is held static and only the output-side pair is pulse-width modulated. In step-down mode the output-side pair is held static and only the input-side pair is modulated. At any moment, therefore, exactly one pair per stage switches at high frequency.

One triangle counter is shared by both stages. Read against the lower half of the duty range, it is the step-up carrier. Offset by half the span, it is the step-down carrier. The two modulation ranges therefore never overlap. A new duty word takes effect only at the carrier valley, so a mode change always falls on a period boundary. Each commutating pair passes through a programmable dead-band stage. Statically held gates bypass that stage. A per-stage enable forces all four of that stage's gates low, which leaves the inductor current to decay through the freewheeling diodes.

Top module: `dual_carrier_pwm`

## Requirements
- R1: While reset is asserted, all eight gates are low. After reset, the carrier starts at its valley (count 0) and is counting up.
- R2: The carrier counts 0, 1, …, PEAK, PEAK−1, …, 1, 0 and then repeats, so one switching period lasts 2·PEAK clocks. PEAK = CLK_HZ/(2·SW_HZ), which is 1250 at the defaults (50 MHz clock, 20 kHz switching).
- R3: A stage's duty word is captured only on the clock edge at which the carrier count is 0. A change at any other time has no effect until the next valley.
- R4: When the captured duty is below 0x8000 (step-up mode), the stage's gate S1 (bit 4·k+0) is high and S2 (bit 4·k+1) is low continuously.
- R5: In step-up mode, the commanded state of S3 (bit 4·k+2) is high when LVL > carrier, where LVL = floor(duty·2·PEAK/65536). S4 (bit 4·k+3) is the complement of S3, apart from dead time.
- R6: When the captured duty is 0x8000 or above (step-down mode), S3 is high and S4 is low continuously.
- R7: In step-down mode, the commanded state of S1 is high when LVL − PEAK > carrier. S2 is the complement of S1, apart from dead time. A duty of exactly 0x8000 therefore keeps S1 low for the whole period.
- R8: The battery stage (k=0) drives gate bits 3:0 and the supercapacitor stage (k=1) drives bits 7:4. The two stages follow their own duty and enable inputs independently.
- R9: A stage whose enable is low has all four of its gates low from the next clock edge. When the stage is re-enabled, a commutating pair first passes through a full dead time.
- R10: When the commanded state of a commutating pair changes, both of its gates are low for exactly dead_clks_i clocks (0 to 255), after which the newly commanded gate turns on. With a setting of 0, the pair swaps on a single edge.
- R11: A statically held gate takes its level on the next clock edge, with no dead time.
- R12: The two gates of a pair are never high together.
- R13: Every gate is registered. Its value after an edge reflects the carrier, the captured duty and the inputs that were present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bat_duty_i | input | 16 | Battery stage duty, unsigned fraction (0x8000 = 0.5) |
| cap_duty_i | input | 16 | Supercapacitor stage duty, unsigned fraction |
| bat_en_i | input | 1 | Battery stage enable; low forces its gates off |
| cap_en_i | input | 1 | Supercapacitor stage enable; low forces its gates off |
| dead_clks_i | input | 8 | Dead time, in clocks, between complementary gates |
| gate_o | output | 8 | Gates S1..S8, where bit i is switch i+1 |

## Verification
A bad carrier count or direction shows up as a shifted edge on the commutating gate within one switching period, and as a wrong period between rising edges. A stale or early-captured duty word shows up as a wrong static pair, or as a wrong pulse width, within the period that follows. A dead-band counter or remembered command in the wrong state appears at the gate pins on the next command change, as an off gap of the wrong length or as an overlap. The bench's per-cycle reference comparison flags each of these on the first clock on which the pins differ.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;
    localparam int DUTY_W = 16;
    localparam int DEAD_W = 8;
    localparam int LEGS   = 2;
    localparam int PAIRS  = 2;

    typedef enum logic {
        LEG_STEP_UP   = 1'b0,
        LEG_STEP_DOWN = 1'b1
    } leg_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } pair_gates_t;
endpackage

// File: rtl/dcpwm_carrier.sv
module dcpwm_carrier #(
    parameter int PEAK = 1250,
    localparam int CW  = $clog2(PEAK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] level_o,
    output logic          valley_o
);
    localparam logic [CW-1:0] PK = CW'(PEAK);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          up;
    } car_st_t;

    car_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.up) begin
            if (s_q.cnt == PK) begin
                s_d.up  = 1'b0;
                s_d.cnt = PK - CW'(1);
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end else begin
            if (s_q.cnt == '0) begin
                s_d.up  = 1'b1;
                s_d.cnt = CW'(1);
            end else begin
                s_d.cnt = s_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.up  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o  = s_q.cnt;
    assign valley_o = (s_q.cnt == '0);

    // R2: the count never leaves 0..PEAK
    p_carrier_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= PK);

    // R2: the count moves by exactly one step on every clock
    p_carrier_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((s_q.cnt == $past(s_q.cnt) + CW'(1)) ||
                          (s_q.cnt == $past(s_q.cnt) - CW'(1))));
endmodule

// File: rtl/dcpwm_deadband.sv
module dcpwm_deadband
    import dcpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              force_i,
    input  logic              cmd_i,
    input  logic [DEAD_W-1:0] dead_i,
    output pair_gates_t       gates_o
);
    typedef struct packed {
        logic              cmd;
        logic [DEAD_W-1:0] cnt;
        pair_gates_t       g;
    } db_st_t;

    db_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en_i) begin
            s_d.g   = '0;
            s_d.cmd = cmd_i;
            s_d.cnt = dead_i;
        end else if (force_i) begin
            s_d.g.hi = 1'b1;
            s_d.g.lo = 1'b0;
            s_d.cmd  = 1'b1;
            s_d.cnt  = '0;
        end else if (cmd_i != s_q.cmd) begin
            s_d.cmd  = cmd_i;
            s_d.cnt  = dead_i;
            s_d.g.hi = (dead_i == '0) && cmd_i;
            s_d.g.lo = (dead_i == '0) && !cmd_i;
        end else if (s_q.cnt != '0) begin
            s_d.cnt  = s_q.cnt - DEAD_W'(1);
            s_d.g.hi = (s_q.cnt == DEAD_W'(1)) && cmd_i;
            s_d.g.lo = (s_q.cnt == DEAD_W'(1)) && !cmd_i;
        end else begin
            s_d.g.hi = cmd_i;
            s_d.g.lo = !cmd_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gates_o = s_q.g;

    // R12: both gates of a pair are never on together
    p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates_o.hi && gates_o.lo));

    // R10: a command change with non-zero dead time opens both gates
    p_gap_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !force_i && (cmd_i != s_q.cmd) && (dead_i != '0))
            |=> (!gates_o.hi && !gates_o.lo));

    // R11: a held gate takes effect on the next edge
    p_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && force_i) |=> (gates_o.hi && !gates_o.lo));

    // R9: disable forces the pair off on the next edge
    p_pair_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!gates_o.hi && !gates_o.lo));
endmodule

// File: rtl/dcpwm_leg.sv
module dcpwm_leg
    import dcpwm_pkg::*;
#(
    parameter int PEAK = 1250,
    localparam int CW  = $clog2(PEAK + 1),
    localparam int LW  = CW + 1,
    localparam int PW  = DUTY_W + LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DEAD_W-1:0] dead_i,
    input  logic [CW-1:0]     level_i,
    input  logic              valley_i,
    output logic [3:0]        gates_o
);
    localparam logic [LW-1:0] SPAN = LW'(2 * PEAK);
    localparam logic [LW-1:0] HALF = LW'(PEAK);

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
    } leg_st_t;

    leg_st_t s_d, s_q;

    leg_mode_e     mode;
    logic [LW-1:0] lvl;
    logic [LW-1:0] lvl_dn;
    logic [LW-1:0] car;
    logic [PAIRS-1:0] force_w;
    logic [PAIRS-1:0] cmd_w;
    pair_gates_t      pg [PAIRS];

    always_comb begin
        s_d = s_q;
        if (valley_i) begin
            s_d.duty = duty_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        mode   = leg_mode_e'(s_q.duty[DUTY_W-1]);
        lvl    = LW'((PW'(s_q.duty) * PW'(SPAN)) >> DUTY_W);
        lvl_dn = lvl - HALF;
        car    = {1'b0, level_i};
        // pair 0: input side (S1/S2); pair 1: output side (S3/S4)
        force_w[0] = (mode == LEG_STEP_UP);
        force_w[1] = (mode == LEG_STEP_DOWN);
        cmd_w[0]   = force_w[0] ? 1'b1 : (lvl_dn > car);
        cmd_w[1]   = force_w[1] ? 1'b1 : (lvl > car);
    end

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        dcpwm_deadband u_db (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_i),
            .force_i (force_w[p]),
            .cmd_i   (cmd_w[p]),
            .dead_i  (dead_i),
            .gates_o (pg[p])
        );
        assign gates_o[2*p]   = pg[p].hi;
        assign gates_o[2*p+1] = pg[p].lo;
    end

    // R3: the captured duty only moves at the valley
    p_duty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !valley_i |=> $stable(s_q.duty));

    // R4: step-up mode holds S1 on and S2 off
    p_up_static_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !s_q.duty[DUTY_W-1]) |=> (gates_o[0] && !gates_o[1]));

    // R6: step-down mode holds S3 on and S4 off
    p_down_static_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && s_q.duty[DUTY_W-1]) |=> (gates_o[2] && !gates_o[3]));
endmodule

// File: rtl/dual_carrier_pwm.sv
module dual_carrier_pwm
    import dcpwm_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int SW_HZ  = 20_000,
    localparam int PEAK  = CLK_HZ / (2 * SW_HZ),
    localparam int CW    = $clog2(PEAK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] bat_duty_i,
    input  logic [DUTY_W-1:0] cap_duty_i,
    input  logic              bat_en_i,
    input  logic              cap_en_i,
    input  logic [DEAD_W-1:0] dead_clks_i,
    output logic [7:0]        gate_o
);
    logic [CW-1:0]     level;
    logic              valley;
    logic [DUTY_W-1:0] duty_w [LEGS];
    logic [LEGS-1:0]   en_w;
    logic [3:0]        leg_g  [LEGS];

    assign duty_w[0] = bat_duty_i;
    assign duty_w[1] = cap_duty_i;
    assign en_w      = {cap_en_i, bat_en_i};

    dcpwm_carrier #(.PEAK(PEAK)) u_car (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_o  (level),
        .valley_o (valley)
    );

    for (genvar k = 0; k < LEGS; k++) begin : g_leg
        dcpwm_leg #(.PEAK(PEAK)) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (en_w[k]),
            .duty_i   (duty_w[k]),
            .dead_i   (dead_clks_i),
            .level_i  (level),
            .valley_i (valley),
            .gates_o  (leg_g[k])
        );
        assign gate_o[4*k +: 4] = leg_g[k];
    end
endmodule

// File: tb/tb_dual_carrier_pwm.sv
module tb_dual_carrier_pwm;
    localparam int PK = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bat_duty = '0;
    logic [15:0] cap_duty = '0;
    logic        bat_en = 1'b1;
    logic        cap_en = 1'b1;
    logic [7:0]  dead = 8'd3;
    logic [7:0]  gate_o;

    int    checks = 0;
    int    fails = 0;
    bit    ended = 0;
    bit    live = 0;
    string phase = "R13";

    always #10 clk = ~clk;

    dual_carrier_pwm #(.CLK_HZ(50_000_000), .SW_HZ(625_000)) dut (
        .clk(clk), .rst_n(rst_n),
        .bat_duty_i(bat_duty), .cap_duty_i(cap_duty),
        .bat_en_i(bat_en), .cap_en_i(cap_en),
        .dead_clks_i(dead), .gate_o(gate_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // behavioural reference model, stepped on every clock edge
    int         mc;
    bit         mup;
    int         mduty [2];
    bit         mcmd  [2][2];
    int         mdt   [2][2];
    logic [7:0] expg;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc = 0; mup = 1; expg = '0;
            for (int l = 0; l < 2; l++) begin
                mduty[l] = 0;
                for (int p = 0; p < 2; p++) begin mcmd[l][p] = 0; mdt[l][p] = 0; end
            end
        end else begin
            logic [7:0] ng;
            ng = '0;
            for (int l = 0; l < 2; l++) begin
                int lv;
                bit down, en;
                lv   = (mduty[l] * 2 * PK) / 65536;
                down = (mduty[l] >= 32768);
                en   = (l == 0) ? bat_en : cap_en;
                for (int p = 0; p < 2; p++) begin
                    bit frc, c, ga, gb;
                    frc = (p == 0) ? !down : down;
                    if (frc) c = 1;
                    else if (p == 0) c = ((lv - PK) > mc);
                    else c = (lv > mc);
                    ga = 0; gb = 0;
                    if (!en) begin
                        mcmd[l][p] = c; mdt[l][p] = int'(dead);
                    end else if (frc) begin
                        ga = 1; mcmd[l][p] = 1; mdt[l][p] = 0;
                    end else if (c != mcmd[l][p]) begin
                        mcmd[l][p] = c; mdt[l][p] = int'(dead);
                        if (dead == 0) begin ga = c; gb = !c; end
                    end else if (mdt[l][p] != 0) begin
                        if (mdt[l][p] == 1) begin ga = c; gb = !c; end
                        mdt[l][p] = mdt[l][p] - 1;
                    end else begin
                        ga = c; gb = !c;
                    end
                    ng[4*l+2*p]   = ga;
                    ng[4*l+2*p+1] = gb;
                end
                if (mc == 0) mduty[l] = (l == 0) ? int'(bat_duty) : int'(cap_duty);
            end
            if (mup) begin
                if (mc == PK) begin mup = 0; mc = PK - 1; end else mc = mc + 1;
            end else begin
                if (mc == 0) begin mup = 1; mc = 1; end else mc = mc - 1;
            end
            expg = ng;
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk(gate_o === expg, phase, int'(gate_o), int'(expg));
            for (int q = 0; q < 4; q++)
                chk(!(gate_o[2*q] && gate_o[2*q+1]), "R12", int'(gate_o), 0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(gate_o == 8'h00, "R1", int'(gate_o), 0);
        rst_n = 1'b1;
        live  = 1;

        // step-up on both stages with different duties
        phase = "R5";
        bat_duty = 16'h4000; cap_duty = 16'h2000; dead = 8'd3;
        repeat (3 * 2 * PK) @(negedge clk);

        // R2 and R4: period between S3 rising edges, and S1 held on
        begin
            int n, lows;
            bit prev;
            prev = gate_o[2];
            while (!( !prev && gate_o[2])) begin prev = gate_o[2]; @(negedge clk); end
            n = 0; lows = 0;
            do begin
                prev = gate_o[2];
                @(negedge clk);
                n++;
                if (!gate_o[0]) lows++;
            end while (!( !prev && gate_o[2]));
            chk(n == 2 * PK, "R2", n, 2 * PK);
            chk(lows == 0, "R4", lows, 0);
        end

        // R10: dead-time gap of 5, then of 0
        for (int t = 0; t < 2; t++) begin
            int want, n;
            bit prev;
            want = (t == 0) ? 5 : 0;
            phase = "R10";
            dead = 8'(want);
            repeat (2 * PK) @(negedge clk);
            prev = gate_o[3];
            while (!(prev && !gate_o[3])) begin prev = gate_o[3]; @(negedge clk); end
            n = 0;
            while (!gate_o[2]) begin n++; @(negedge clk); end
            chk(n == want, "R10", n, want);
        end

        // step-down on both stages, including the 0x8000 boundary
        phase = "R7";
        dead = 8'd2;
        bat_duty = 16'hC000; cap_duty = 16'h8000;
        repeat (3 * 2 * PK) @(negedge clk);
        begin
            int s3low, s5high;
            s3low = 0; s5high = 0;
            for (int i = 0; i < 2 * PK; i++) begin
                @(negedge clk);
                if (!gate_o[2]) s3low++;
                if (gate_o[4]) s5high++;
            end
            chk(s3low == 0, "R6", s3low, 0);
            chk(s5high == 0, "R7", s5high, 0);
        end

        // R3: a mid-period duty change waits for the valley
        phase = "R3";
        while (mc != PK / 2) @(negedge clk);
        bat_duty = 16'h2000;
        @(negedge clk);
        chk(gate_o[3:2] == 2'b01, "R3", int'(gate_o[3:2]), 1);
        phase = "R11";
        repeat (2 * 2 * PK) @(negedge clk);
        chk(gate_o[1:0] == 2'b01, "R11", int'(gate_o[1:0]), 1);

        // R9 / R8: disable the battery stage, supercapacitor keeps running
        cap_duty = 16'hFFFF;
        repeat (2 * PK) @(negedge clk);
        phase = "R8";
        bat_en = 1'b0;
        begin
            int on_cnt;
            on_cnt = 0;
            for (int i = 0; i < 2 * PK; i++) begin
                @(negedge clk);
                if (gate_o[3:0] != 4'h0) on_cnt++;
            end
            chk(on_cnt == 0, "R9", on_cnt, 0);
        end
        phase = "R9";
        bat_en = 1'b1;
        repeat (2 * 2 * PK) @(negedge clk);

        // sweep of extremes with mode flips
        phase = "R13";
        bat_duty = 16'hFFFF; cap_duty = 16'h0000; dead = 8'd7;
        repeat (2 * 2 * PK) @(negedge clk);
        bat_duty = 16'h7FFF; cap_duty = 16'h8001;
        repeat (2 * 2 * PK) @(negedge clk);
        cap_en = 1'b0;
        repeat (PK) @(negedge clk);
        cap_en = 1'b1;
        repeat (2 * 2 * PK) @(negedge clk);

        live = 0;
        finish_run();
    end
endmodule